// File: doc/BRIEF.md
# Cross-Domain Timestamp Capture Queue

This block records when precision-time frames pass a byte-wide network datapath. At the start of every frame the byte-clock side asks the real-time-clock domain for the current time. It uses a request/acknowledge handshake whose two control lines each cross through a two-flop synchronizer. The answered time is held steady in the clock domain until the handshake releases, and the byte side copies it only after it has seen the synchronized acknowledge.

When the frame parser delivers its verdict, the byte side acts on it. If the verdict says the frame carries the timing protocol, the captured time joins the low 30 bits of the parser's identification word, and the 110-bit record is written into an eight-entry asynchronous queue. If the verdict says it does not, the captured time is thrown away. The host clock domain reads the queue through a pop input and an empty flag. The oldest record is presented on the output whenever the queue is not empty.

The queue keeps a write index and a read index that both start at zero. Each index crosses into the other domain in Gray code through two-flop synchronizers. Full and empty are derived from these synchronized copies, so the queue never overwrites a held record and never advances past the last one.

Top module: `ts_capture_queue`

## Requirements
- R1: A record is 110 bits. Bits [109:62] hold the 48-bit seconds value, bits [61:30] hold the 32-bit nanoseconds value, and bits [29:0] hold bits [29:0] of the parser identification word; identification bits 31:30 are discarded.
- R2: The time stored in a record is the `rtc_sec`/`rtc_ns` value present around the rising edge of `frame_valid`. Changes to the time inputs after the handshake has completed do not alter the record.
- R3: The capture request stays high until the synchronized acknowledge returns. A rising edge of `frame_valid` that arrives while a capture is still pending is ignored.
- R4: Only the first verdict pulse (`verdict_valid` high) after an accepted frame start is used; a verdict pulse with no frame in progress is ignored.
- R5: A verdict with `verdict_ptp` low produces no record, and the captured time is discarded.
- R6: A record that becomes ready while the queue already holds 8 entries is discarded; the stored entries are left unchanged.
- R7: `host_empty` is high out of reset. When `host_empty` is low, `host_record` shows the oldest stored record, and a `host_pop` sampled high on a `host_clk` rising edge removes it. A pop while empty has no effect.
- R8: Records leave in the order they were committed, including after the indexes wrap, and each cross-domain index changes by at most one bit per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| byte_clk | input | 1 | Datapath byte clock; queue write side |
| byte_rst_n | input | 1 | Synchronous active-low reset, byte domain |
| frame_valid | input | 1 | High while a frame is on the datapath; its rising edge starts a capture |
| verdict_valid | input | 1 | One-cycle pulse carrying the parser verdict |
| verdict_ptp | input | 1 | Verdict: 1 = timing-protocol frame, 0 = other |
| pkt_ident | input | 32 | Parser identification word, valid with `verdict_valid` |
| rtc_clk | input | 1 | Real-time clock domain clock |
| rtc_rst_n | input | 1 | Synchronous active-low reset, clock domain |
| rtc_sec | input | 48 | Current seconds |
| rtc_ns | input | 32 | Current nanoseconds |
| host_clk | input | 1 | Host read clock |
| host_rst_n | input | 1 | Synchronous active-low reset, host domain |
| host_pop | input | 1 | Remove the oldest record |
| host_empty | output | 1 | Queue holds no record |
| host_record | output | 110 | Oldest record (layout in R1) |

## Verification
The bench builds the block with its default 8-entry queue and two synchronizer stages, and runs three unrelated clocks of 5, 7 and 6 ns. With only eight entries, a burst of ten frames with reads held off fills the queue and forces two drops. The drain that follows, plus one more frame, carries both indexes through their wrap. Identification words with bits 31:30 set check the truncation, and rewriting the time inputs after every handshake shows that no late time reaches a record.

// File: rtl/ts_cq_pkg.sv
// Shared widths and types for the timestamp capture queue.
// Assumes: the time is seconds followed by nanoseconds, and the record appends the packet ID.
package ts_cq_pkg;
    localparam int SEC_W  = 48;
    localparam int NS_W   = 32;
    localparam int ID_W   = 30;
    localparam int TIME_W = SEC_W + NS_W;
    localparam int REC_W  = TIME_W + ID_W;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
        logic [ID_W-1:0]  id;
    } ts_rec_t;

    typedef enum logic [1:0] {
        CAP_IDLE,
        CAP_REQ,
        CAP_RELEASE
    } cap_state_e;
endpackage

// File: rtl/ts_cq_sync.sv
// Multi-stage flop synchronizer for signals entering the clock domain clk.
// Assumes: a multi-bit input is either Gray coded or held stable long enough to settle.
module ts_cq_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    // First stage samples the foreign signal.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Each further stage lets metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ts_cq_rtc_side.sv
// Clock-domain half of the capture handshake: on a synchronized request it latches
// the current time, raises ack, and holds both until the request falls.
// Assumes: req_async toggles only under the four-phase protocol.
module ts_cq_rtc_side
    import ts_cq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              rtc_clk,
    input  logic              rtc_rst_n,
    input  logic              req_async,
    input  logic [SEC_W-1:0]  rtc_sec,
    input  logic [NS_W-1:0]   rtc_ns,
    output logic              ack,
    output logic [TIME_W-1:0] held_time
);
    logic req_s;

    ts_cq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk(rtc_clk), .rst_n(rtc_rst_n), .d(req_async), .q(req_s)
    );

    // Latch the time on a new request; drop ack once the request is withdrawn.
    always_ff @(posedge rtc_clk) begin
        if (!rtc_rst_n) begin
            ack       <= 1'b0;
            held_time <= '0;
        end else if (req_s && !ack) begin
            held_time <= {rtc_sec, rtc_ns};
            ack       <= 1'b1;
        end else if (!req_s && ack) begin
            ack       <= 1'b0;
        end
    end

    AST_ACK_NEEDS_REQ: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
        $rose(ack) |-> $past(req_s)); // R3
    AST_HELD_STABLE: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
        (ack && $past(ack)) |-> $stable(held_time)); // R2
endmodule

// File: rtl/ts_cq_capture.sv
// Byte-domain capture control: detects frame start, runs the request side of the
// time handshake, collects the first parser verdict, and commits or drops the record.
// Assumes: verdict_valid is a single-cycle pulse in byte_clk.
module ts_cq_capture
    import ts_cq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_valid,
    input  logic              verdict_valid,
    input  logic              verdict_ptp,
    input  logic [ID_W-1:0]   verdict_id,
    input  logic              ack_async,
    input  logic [TIME_W-1:0] held_time,
    input  logic              wr_full,
    output logic              req,
    output logic              wr_en,
    output ts_rec_t           wr_rec
);
    cap_state_e        state;
    logic              ack_s;
    logic              fv_q;
    logic              vseen;
    logic              vptp;
    logic [ID_W-1:0]   id_q;
    logic [TIME_W-1:0] time_q;

    ts_cq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(ack_async), .q(ack_s)
    );

    // Handshake sequencing and verdict capture for one frame at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= CAP_IDLE;
            fv_q   <= 1'b0;
            req    <= 1'b0;
            vseen  <= 1'b0;
            vptp   <= 1'b0;
            id_q   <= '0;
            time_q <= '0;
        end else begin
            fv_q <= frame_valid;
            case (state)
                CAP_IDLE: begin
                    if (frame_valid && !fv_q) begin
                        state <= CAP_REQ;
                        req   <= 1'b1;
                        vseen <= 1'b0;
                    end
                end
                CAP_REQ: begin
                    if (ack_s) begin
                        time_q <= held_time;
                        req    <= 1'b0;
                        state  <= CAP_RELEASE;
                    end
                end
                CAP_RELEASE: begin
                    if (!ack_s && vseen) state <= CAP_IDLE;
                end
                default: state <= CAP_IDLE;
            endcase
            if (state != CAP_IDLE && !vseen && verdict_valid) begin
                vseen <= 1'b1;
                vptp  <= verdict_ptp;
                id_q  <= verdict_id;
            end
        end
    end

    // Commit when the handshake is closed, the verdict is PTP and room exists.
    always_comb begin
        wr_en      = (state == CAP_RELEASE) && !ack_s && vseen && vptp && !wr_full;
        wr_rec.sec = time_q[TIME_W-1:NS_W];
        wr_rec.ns  = time_q[NS_W-1:0];
        wr_rec.id  = id_q;
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack_s) |=> req); // R3
    AST_ONE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R4
endmodule

// File: rtl/ts_cq_afifo.sv
// Dual-clock queue with Gray-coded indexes crossing through synchronizers.
// Output is show-ahead: rd_data is the oldest entry whenever rd_empty is low.
// Assumes: DEPTH is a power of two, at least 4.
module ts_cq_afifo #(
    parameter int WIDTH       = 110,
    parameter int DEPTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             wr_clk,
    input  logic             wr_rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             wr_full,
    input  logic             rd_clk,
    input  logic             rd_rst_n,
    input  logic             rd_pop,
    output logic             rd_empty,
    output logic [WIDTH-1:0] rd_data
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PTR_W  = ADDR_W + 1;
    localparam logic [PTR_W-1:0] FULL_FLIP = {2'b11, {(PTR_W-2){1'b0}}};

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_bin, wr_gray, rd_gray_s;
    logic [PTR_W-1:0] rd_bin, rd_gray, wr_gray_s;
    logic [PTR_W-1:0] wr_bin_nx, rd_bin_nx;

    assign wr_bin_nx = wr_bin + 1'b1;
    assign rd_bin_nx = rd_bin + 1'b1;
    assign wr_full   = (wr_gray == (rd_gray_s ^ FULL_FLIP));
    assign rd_empty  = (rd_gray == wr_gray_s);
    assign rd_data   = mem[rd_bin[ADDR_W-1:0]];

    ts_cq_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_rd2wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_gray), .q(rd_gray_s)
    );
    ts_cq_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_wr2rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_gray), .q(wr_gray_s)
    );

    // Store a record at the write index when not full.
    always_ff @(posedge wr_clk) begin
        if (wr_en && !wr_full) mem[wr_bin[ADDR_W-1:0]] <= wr_data;
    end

    // Advance the write index in binary and Gray form.
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            wr_bin  <= '0;
            wr_gray <= '0;
        end else if (wr_en && !wr_full) begin
            wr_bin  <= wr_bin_nx;
            wr_gray <= wr_bin_nx ^ (wr_bin_nx >> 1);
        end
    end

    // Advance the read index in binary and Gray form.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rd_bin  <= '0;
            rd_gray <= '0;
        end else if (rd_pop && !rd_empty) begin
            rd_bin  <= rd_bin_nx;
            rd_gray <= rd_bin_nx ^ (rd_bin_nx >> 1);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_en |-> !wr_full); // R6
    AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_pop && rd_empty) |=> $stable(rd_bin)); // R7
    AST_WR_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1); // R8
    AST_RD_GRAY_STEP: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $countones(rd_gray ^ $past(rd_gray)) <= 1); // R8
endmodule

// File: rtl/ts_capture_queue.sv
// Top: time capture handshake, frame verdict handling, and a dual-clock record queue.
// Assumes: three independent clocks (byte, real-time clock, host), each with its own reset.
module ts_capture_queue
    import ts_cq_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ID_IN_W     = 32
) (
    input  logic               byte_clk,
    input  logic               byte_rst_n,
    input  logic               frame_valid,
    input  logic               verdict_valid,
    input  logic               verdict_ptp,
    input  logic [ID_IN_W-1:0] pkt_ident,
    input  logic               rtc_clk,
    input  logic               rtc_rst_n,
    input  logic [SEC_W-1:0]   rtc_sec,
    input  logic [NS_W-1:0]    rtc_ns,
    input  logic               host_clk,
    input  logic               host_rst_n,
    input  logic               host_pop,
    output logic               host_empty,
    output logic [REC_W-1:0]   host_record
);
    logic              req, ack, wr_en, wr_full;
    logic [TIME_W-1:0] held_time;
    ts_rec_t           wr_rec;
    logic              unused_id_hi;

    assign unused_id_hi = ^pkt_ident[ID_IN_W-1:ID_W];

    ts_cq_rtc_side #(.SYNC_STAGES(SYNC_STAGES)) u_rtc (
        .rtc_clk(rtc_clk), .rtc_rst_n(rtc_rst_n), .req_async(req),
        .rtc_sec(rtc_sec), .rtc_ns(rtc_ns), .ack(ack), .held_time(held_time)
    );

    ts_cq_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk(byte_clk), .rst_n(byte_rst_n), .frame_valid(frame_valid),
        .verdict_valid(verdict_valid), .verdict_ptp(verdict_ptp),
        .verdict_id(pkt_ident[ID_W-1:0]), .ack_async(ack), .held_time(held_time),
        .wr_full(wr_full), .req(req), .wr_en(wr_en), .wr_rec(wr_rec)
    );

    ts_cq_afifo #(.WIDTH(REC_W), .DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_fifo (
        .wr_clk(byte_clk), .wr_rst_n(byte_rst_n), .wr_en(wr_en), .wr_data(wr_rec),
        .wr_full(wr_full), .rd_clk(host_clk), .rd_rst_n(host_rst_n),
        .rd_pop(host_pop), .rd_empty(host_empty), .rd_data(host_record)
    );
endmodule

// File: tb/ts_capture_queue_bench.sv
// Scoreboard bench: the frame driver queues expected records, the host monitor pops and compares.
module ts_capture_queue_bench;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DEPTH = 8;

    logic byte_clk = 0, rtc_clk = 0, host_clk = 0;
    logic byte_rst_n = 0, rtc_rst_n = 0, host_rst_n = 0;
    logic frame_valid = 0, verdict_valid = 0, verdict_ptp = 0;
    logic [31:0]  pkt_ident = '0;
    logic [47:0]  rtc_sec = '0;
    logic [31:0]  rtc_ns = '0;
    logic         host_pop = 0;
    logic         host_empty;
    logic [109:0] host_record;

    logic [109:0] exp_q[$];
    int  checks = 0, errors = 0;
    bit  rd_enable = 1, force_pop = 0, finished = 0;

    always #2.5 byte_clk = ~byte_clk;
    always #3.5 rtc_clk  = ~rtc_clk;
    always #3.0 host_clk = ~host_clk;

    ts_capture_queue u_ts_capture_queue (
        .byte_clk(byte_clk), .byte_rst_n(byte_rst_n), .frame_valid(frame_valid),
        .verdict_valid(verdict_valid), .verdict_ptp(verdict_ptp), .pkt_ident(pkt_ident),
        .rtc_clk(rtc_clk), .rtc_rst_n(rtc_rst_n), .rtc_sec(rtc_sec), .rtc_ns(rtc_ns),
        .host_clk(host_clk), .host_rst_n(host_rst_n), .host_pop(host_pop),
        .host_empty(host_empty), .host_record(host_record)
    );

    task automatic check(input bit ok, input string req, input logic [109:0] act,
                         input logic [109:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Monitor: pops and compares each record the host side sees (R1, R7, R8).
    always @(negedge host_clk) begin
        if (rd_enable && host_rst_n && !host_empty) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 R6 unexpected record", host_record, '0);
            end else begin
                logic [109:0] e;
                e = exp_q.pop_front();
                check(host_record === e, "R1 R2 R8 record content/order", host_record, e);
            end
            host_pop = 1;
        end else begin
            host_pop = force_pop;
        end
    end

    task automatic pulse_verdict(input bit ptp, input logic [31:0] id);
        verdict_valid = 1; verdict_ptp = ptp; pkt_ident = id;
        @(negedge byte_clk);
        verdict_valid = 0; verdict_ptp = 0;
    endtask

    // Driver: one frame, expected record queued when the verdict is PTP and room exists.
    task automatic send_frame(input logic [47:0] sec, input logic [31:0] ns,
                              input logic [31:0] id, input bit ptp, input bit late,
                              input bit double_rise, input bit extra_verdict);
        if (ptp && exp_q.size() < DEPTH) exp_q.push_back({sec, ns, id[29:0]});
        @(negedge rtc_clk);
        rtc_sec = sec; rtc_ns = ns;
        @(negedge byte_clk);
        frame_valid = 1;
        if (double_rise) begin
            @(negedge byte_clk) frame_valid = 0;
            @(negedge byte_clk) frame_valid = 1;
        end
        if (!late) begin
            repeat (2) @(negedge byte_clk);
            pulse_verdict(ptp, id);
            if (extra_verdict) pulse_verdict(1'b1, ~id);
        end
        repeat (30) @(negedge byte_clk);
        @(negedge rtc_clk);
        rtc_sec = ~sec; rtc_ns = ns + 32'd12345;
        @(negedge byte_clk);
        if (late) pulse_verdict(ptp, id);
        frame_valid = 0;
        repeat (20) @(negedge byte_clk);
    endtask

    task automatic expect_idle_empty(input string req);
        repeat (20) @(negedge host_clk);
        check(host_empty === 1'b1, req, {109'd0, host_empty}, 110'd1);
        check(exp_q.size() == 0, req, exp_q.size(), 110'd0);
    endtask

    initial begin
        repeat (100000) @(posedge byte_clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (10) @(negedge byte_clk);
        byte_rst_n = 1; rtc_rst_n = 1; host_rst_n = 1;
        @(negedge host_clk);
        // R7: empty out of reset
        check(host_empty === 1'b1, "R7 empty after reset", {109'd0, host_empty}, 110'd1);

        // R7: pop while empty has no effect
        force_pop = 1;
        repeat (5) @(negedge host_clk);
        force_pop = 0;
        check(host_empty === 1'b1, "R7 pop while empty", {109'd0, host_empty}, 110'd1);

        // R1 R2: basic capture, ID bits 31:30 set and dropped
        send_frame(48'h0000_1234_5678, 32'h1111_2222, 32'hC000_0ABC, 1, 0, 0, 0);
        // R2: verdict after time inputs changed
        send_frame(48'h0A0B_0C0D_0E0F, 32'h3B9A_C9FF, 32'h4123_4567, 1, 1, 0, 0);
        // R5 R4: non-PTP verdict, second verdict ignored
        send_frame(48'h0000_0000_0042, 32'h0000_0100, 32'h0000_0077, 0, 0, 0, 1);
        expect_idle_empty("R5 R4 non-PTP frame dropped");
        // R4: verdict with no frame ignored
        @(negedge byte_clk);
        pulse_verdict(1'b1, 32'h1234_5678);
        expect_idle_empty("R4 verdict without frame ignored");
        // R3: second rise while pending ignored
        send_frame(48'h0000_0000_0777, 32'h0000_0ABC, 32'h8000_0003, 1, 0, 1, 0);
        expect_idle_empty("R3 second frame start ignored");
        // R8: several frames in order
        for (int i = 0; i < 4; i++)
            send_frame(48'h1000 + i, 32'h2000 * (i + 1), 32'hF000_0000 | i, 1, i[0], 0, 0);
        expect_idle_empty("R8 sequence drained");

        // R6: fill with reads held off; last two dropped
        rd_enable = 0;
        for (int i = 0; i < 10; i++)
            send_frame(48'h5000 + i, 32'h100 + i, 32'h3000_0000 + i, 1, 0, 0, 0);
        check(exp_q.size() == DEPTH, "R6 model holds 8", exp_q.size(), DEPTH);
        check(host_empty === 1'b0, "R6 queue holds data", {109'd0, host_empty}, 110'd0);
        rd_enable = 1;
        expect_idle_empty("R6 drained after full");

        // R8: one more record after index wrap
        send_frame(48'h7777, 32'h8888, 32'h0000_0999, 1, 0, 0, 0);
        expect_idle_empty("R8 after wrap");

        finish_run();
    end
endmodule